// File: doc/BRIEF.md
# Parallel Port Tagged Byte FIFO

This block is the byte queue behind the FIFO-driven modes of a parallel port controller. It takes bytes from host writes (CPU or DMA) and from the port receive path. It hands them to the port transmit path or back to host reads. The current port mode and direction decide which of these sources and sinks are active.

Every entry carries one tag bit beside its data byte. In the extended-capability forward direction, the host writes either a data byte or an address/command byte. Both kinds enter the same queue in the order they arrive, and the tag records the kind so that the transmit engine can present each byte correctly. The queue is held empty while the port is in its plain compatible mode.

A diagnostic mode lets the host both fill and drain the queue, and nothing reaches the port in that mode. The full and empty guards are also lifted there, so both pointers run freely modulo the depth.

Top module: `ppf_queue`

## Requirements
- R1: After reset, empty_o is 1, and full_o, thresh_o, overflow_o, port_tx_valid_o, rd_data_o and rd_cmd_o are all 0.
- R2: While mode_i is 3'b000 (compatible mode), the queue is held empty, writes are ignored and overflow_o is cleared. The stored contents are discarded once that mode is left.
- R3: Bytes leave the queue in the order they were accepted. rd_data_o and rd_cmd_o show a popped entry from the clock edge that accepts the pop onward, and they keep that value until the next accepted pop.
- R4: In mode 3'b011 with dir_i=0, each host write stores host_wr_cmd_i as its tag (1 means address/command, 0 means data), and the tag comes out on rd_cmd_o. In mode 3'b010, every entry is tagged 0.
- R5: In mode 3'b011 with dir_i=1, port_rx_i writes port_rx_data_i with tag 0, host writes are ignored, and host_rd_i pops the queue.
- R6: empty_o is 1 exactly when the fill level is 0, and full_o is 1 exactly when the level equals DEPTH (16 by default).
- R7: thresh_o is 1 exactly when the fill level is at least THRESH (8 by default).
- R8: Outside mode 3'b110, a write while full is dropped and sets overflow_o. overflow_o stays set until mode 3'b000 is entered.
- R9: Outside mode 3'b110, a pop while empty is ignored. The read pointer does not move and rd_data_o holds its previous value.
- R10: In mode 3'b110, host writes and host reads are both accepted whatever the fill level, port_tx_valid_o stays 0, and both pointers wrap modulo DEPTH. The 17th write therefore overwrites slot 0, and a read past empty returns the stale slot contents.
- R11: port_tx_valid_o equals !empty_o in mode 3'b010 and in mode 3'b011 with dir_i=0, and is 0 in every other case. port_tx_rd_i pops only while port_tx_valid_o is 1.
- R12: In modes 3'b001, 3'b100 and 3'b111, all writes and pops are ignored, and the contents and flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Port operating mode |
| dir_i | input | 1 | Port direction, 1 = reverse |
| host_wr_i | input | 1 | Host (CPU/DMA) write strobe |
| host_wr_data_i | input | 8 | Host write byte |
| host_wr_cmd_i | input | 1 | Host write targets the address/command location |
| host_rd_i | input | 1 | Host (CPU/DMA) read strobe |
| port_rx_i | input | 1 | Byte received from the port |
| port_rx_data_i | input | 8 | Received byte |
| port_tx_rd_i | input | 1 | Transmit engine takes the head entry |
| port_tx_valid_o | output | 1 | Head entry is available for transmission |
| rd_data_o | output | 8 | Byte of the last accepted pop |
| rd_cmd_o | output | 1 | Tag of the last accepted pop |
| full_o | output | 1 | Level equals DEPTH |
| empty_o | output | 1 | Level is zero |
| thresh_o | output | 1 | Level at or above THRESH |
| overflow_o | output | 1 | Sticky dropped-write flag |

## Verification
The hardest state to reach is the diagnostic-mode wrap. The write pointer has to go all the way around past the read pointer, and the read pointer then has to run past the write pointer, so that overwritten and stale slots are returned. The bench first clears both pointers through the compatible mode. It then enters the diagnostic mode, writes DEPTH+1 bytes and reads DEPTH+2 bytes. The expected byte of each read is worked out from the slot index modulo the depth. The sticky overflow is also followed across a change into another non-clearing mode before the compatible mode clears it.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
   typedef enum logic [2:0] {
      PM_COMPAT = 3'b000,
      PM_BIDIR  = 3'b001,
      PM_AUTO   = 3'b010,
      PM_XCAP   = 3'b011,
      PM_EPAR   = 3'b100,
      PM_SPARE  = 3'b101,
      PM_DIAG   = 3'b110,
      PM_SETUP  = 3'b111
   } port_mode_e;
endpackage

// File: rtl/ppf_mode_dec.sv
module ppf_mode_dec
   import ppf_pkg::*;
(
   input  logic [2:0] mode_i,
   input  logic       dir_i,
   input  logic       host_wr_i,
   input  logic       host_wr_cmd_i,
   input  logic       host_rd_i,
   input  logic       port_rx_i,
   input  logic       port_tx_rd_i,
   output logic       clr_o,
   output logic       diag_o,
   output logic       tx_en_o,
   output logic       push_req_o,
   output logic       push_from_rx_o,
   output logic       push_tag_o,
   output logic       host_pop_req_o,
   output logic       tx_pop_req_o
);
   port_mode_e mode;
   logic       host_wr_en;

   always_comb begin
      mode           = port_mode_e'(mode_i);
      clr_o          = (mode == PM_COMPAT);
      diag_o         = (mode == PM_DIAG);
      tx_en_o        = (mode == PM_AUTO) || ((mode == PM_XCAP) && !dir_i);
      host_wr_en     = tx_en_o || diag_o;
      push_from_rx_o = (mode == PM_XCAP) && dir_i && port_rx_i;
      push_req_o     = push_from_rx_o || (host_wr_en && host_wr_i);
      push_tag_o     = !push_from_rx_o && (mode == PM_XCAP) && host_wr_cmd_i;
      host_pop_req_o = host_rd_i && (diag_o || ((mode == PM_XCAP) && dir_i));
      tx_pop_req_o   = port_tx_rd_i && tx_en_o;
   end
endmodule

// File: rtl/ppf_ptr.sv
module ppf_ptr #(
   parameter int AW = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        inc_i,
   output logic [AW:0] ptr_o
);
   initial assert (AW >= 1) else $error("ppf_ptr: AW must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (clr_i)  ptr_o <= '0;
      else if (inc_i)  ptr_o <= ptr_o + 1'b1;
   end

   // R2: the clear wins over an increment in the same cycle
   a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ptr_o == '0));
endmodule

// File: rtl/ppf_store.sv
module ppf_store #(
   parameter int DEPTH = 16,
   parameter int W     = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == AW'(i))) slot_q[i] <= wdata_i;
      end
   end

   assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/ppf_queue.sv
module ppf_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int THRESH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              dir_i,
   input  logic              host_wr_i,
   input  logic [DATA_W-1:0] host_wr_data_i,
   input  logic              host_wr_cmd_i,
   input  logic              host_rd_i,
   input  logic              port_rx_i,
   input  logic [DATA_W-1:0] port_rx_data_i,
   input  logic              port_tx_rd_i,
   output logic              port_tx_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_cmd_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              thresh_o,
   output logic              overflow_o
);
   localparam int AW = $clog2(DEPTH);
   localparam int EW = DATA_W + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("ppf_queue: DEPTH must be a power of two, at least 2");
      assert (THRESH >= 0 && THRESH <= DEPTH)
         else $error("ppf_queue: THRESH out of range");
      assert (DATA_W >= 1) else $error("ppf_queue: DATA_W must be positive");
   end

   logic        clr, diag, tx_en, push_req, push_rx, push_tag;
   logic        host_pop_req, tx_pop_req, pop_req;
   logic        push_ok, pop_ok;
   logic [AW:0] wptr, rptr, level;
   logic [EW-1:0] wentry, rentry;
   logic [DATA_W-1:0] rd_q;
   logic        tag_q, ovf_q;

   ppf_mode_dec u_dec (
      .mode_i        (mode_i),
      .dir_i         (dir_i),
      .host_wr_i     (host_wr_i),
      .host_wr_cmd_i (host_wr_cmd_i),
      .host_rd_i     (host_rd_i),
      .port_rx_i     (port_rx_i),
      .port_tx_rd_i  (port_tx_rd_i),
      .clr_o         (clr),
      .diag_o        (diag),
      .tx_en_o       (tx_en),
      .push_req_o    (push_req),
      .push_from_rx_o(push_rx),
      .push_tag_o    (push_tag),
      .host_pop_req_o(host_pop_req),
      .tx_pop_req_o  (tx_pop_req)
   );

   assign level   = wptr - rptr;
   assign empty_o = (level == '0);
   assign full_o  = (level == (AW+1)'(DEPTH));

   if (THRESH == 0) begin : g_thr_always
      assign thresh_o = 1'b1;
   end else begin : g_thr_cmp
      assign thresh_o = (level >= (AW+1)'(THRESH));
   end

   assign pop_req = host_pop_req || (tx_pop_req && !empty_o);
   assign push_ok = push_req && (diag || !full_o);
   assign pop_ok  = pop_req  && (diag || !empty_o);
   assign wentry  = {push_tag, push_rx ? port_rx_data_i : host_wr_data_i};

   ppf_ptr #(.AW(AW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(push_ok), .ptr_o(wptr));

   ppf_ptr #(.AW(AW)) u_rptr (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(pop_ok), .ptr_o(rptr));

   ppf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
      .clk    (clk),
      .we_i   (push_ok),
      .waddr_i(wptr[AW-1:0]),
      .wdata_i(wentry),
      .raddr_i(rptr[AW-1:0]),
      .rdata_o(rentry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         tag_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (pop_ok) begin
            rd_q  <= rentry[DATA_W-1:0];
            tag_q <= rentry[DATA_W];
         end
         if (clr)                               ovf_q <= 1'b0;
         else if (push_req && full_o && !diag)  ovf_q <= 1'b1;
      end
   end

   assign rd_data_o       = rd_q;
   assign rd_cmd_o        = tag_q;
   assign overflow_o      = ovf_q;
   assign port_tx_valid_o = tx_en && !empty_o;

   // R2: the compatible mode leaves the queue empty
   a_r2_compat_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b000) |=> empty_o);
   // R8: a write that finds the queue full leaves the write pointer alone
   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full_o && !diag && !clr) |=> $stable(wptr));
   // R8: the overflow flag is sticky until the compatible mode
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && mode_i != 3'b000) |=> overflow_o);
   // R9: a pop that finds the queue empty keeps the read byte
   a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty_o && !diag) |=> $stable(rd_data_o));
   // R10: nothing is offered to the port in the diagnostic mode
   a_r10_diag_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'b110) |-> !port_tx_valid_o);
   // R6: the two level flags never show together
   a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));
endmodule

// File: tb/ppf_queue_tb.sv
`timescale 1ns/1ps
module ppf_queue_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic       dir = 1'b0;
   logic       hw = 1'b0, hcmd = 1'b0, hr = 1'b0, rx = 1'b0, txr = 1'b0;
   logic [7:0] hdata = '0, rxdata = '0;
   logic       txv, rcmd, full, empty, thr, ovf;
   logic [7:0] rdata;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   ppf_queue dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir),
      .host_wr_i(hw), .host_wr_data_i(hdata), .host_wr_cmd_i(hcmd),
      .host_rd_i(hr), .port_rx_i(rx), .port_rx_data_i(rxdata),
      .port_tx_rd_i(txr), .port_tx_valid_o(txv), .rd_data_o(rdata),
      .rd_cmd_o(rcmd), .full_o(full), .empty_o(empty), .thresh_o(thr),
      .overflow_o(ovf));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic hwrite(input logic [7:0] d, input logic c);
      hdata = d; hcmd = c; hw = 1'b1;
      @(negedge clk); hw = 1'b0; hcmd = 1'b0;
   endtask

   task automatic hread();
      hr = 1'b1;
      @(negedge clk); hr = 1'b0;
   endtask

   task automatic txpop();
      txr = 1'b1;
      @(negedge clk); txr = 1'b0;
   endtask

   task automatic prx(input logic [7:0] d);
      rxdata = d; rx = 1'b1;
      @(negedge clk); rx = 1'b0;
   endtask

   task automatic setmode(input logic [2:0] m, input logic d);
      mode = m; dir = d;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state straight out of reset
      chk_eq("R1 empty", empty, 1); chk_eq("R1 full", full, 0);
      chk_eq("R1 thresh", thr, 0);  chk_eq("R1 overflow", ovf, 0);
      chk_eq("R1 tx_valid", txv, 0); chk_eq("R1 rd_data", rdata, 0);
      chk_eq("R1 rd_cmd", rcmd, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: writes in the compatible mode are ignored
      hwrite(8'h55, 1'b0); hwrite(8'h66, 1'b1);
      chk_eq("R2 compat write ignored", empty, 1);

      // automatic mode fill sweep: R6 R7 R11
      setmode(3'b010, 1'b0);
      for (int k = 0; k < 16; k++) begin
         hwrite(8'h10 + 8'(k), 1'b1);
         chk_eq("R6 empty during fill", empty, 0);
         chk_eq("R6 full during fill", full, (k + 1 == 16) ? 1 : 0);
         chk_eq("R7 thresh during fill", thr, (k + 1 >= 8) ? 1 : 0);
         chk_eq("R11 tx_valid during fill", txv, 1);
      end
      // R8: a write into the full queue is dropped
      hwrite(8'hEE, 1'b0);
      chk_eq("R8 overflow set", ovf, 1);
      chk_eq("R8 still full", full, 1);
      // drain via the transmit path: R3 R4 R6 R7
      for (int k = 0; k < 16; k++) begin
         txpop();
         chk_eq("R3 drain order", rdata, 8'h10 + k);
         chk_eq("R4 auto mode tag zero", rcmd, 0);
         chk_eq("R6 full during drain", full, 0);
         chk_eq("R6 empty during drain", empty, (k == 15) ? 1 : 0);
         chk_eq("R7 thresh during drain", thr, (16 - k - 1 >= 8) ? 1 : 0);
      end
      chk_eq("R11 tx_valid when empty", txv, 0);
      // R9: a pop on empty does nothing
      txpop();
      chk_eq("R9 rd_data held", rdata, 8'h1F);
      chk_eq("R9 still empty", empty, 1);

      // R12: another mode keeps the overflow and ignores writes
      setmode(3'b100, 1'b0);
      hwrite(8'h77, 1'b0);
      chk_eq("R12 write ignored", empty, 1);
      chk_eq("R8 overflow sticky across modes", ovf, 1);
      setmode(3'b000, 1'b0);
      chk_eq("R2 overflow cleared", ovf, 0);

      // extended-capability forward: R4 R12 R3
      setmode(3'b011, 1'b0);
      for (int k = 0; k < 6; k++) hwrite(8'h40 + 8'(3 * k), 1'(k % 2));
      setmode(3'b111, 1'b0);
      chk_eq("R11 tx_valid off in setup mode", txv, 0);
      hwrite(8'h99, 1'b1); txpop(); hread();
      chk_eq("R12 contents kept", empty, 0);
      chk_eq("R12 rd_data unchanged", rdata, 8'h1F);
      setmode(3'b011, 1'b0);
      chk_eq("R11 tx_valid forward", txv, 1);
      for (int k = 0; k < 6; k++) begin
         txpop();
         chk_eq("R3 forward order", rdata, 8'h40 + 3 * k);
         chk_eq("R4 forward tag", rcmd, k % 2);
      end
      chk_eq("R12 setup write not stored", empty, 1);

      // extended-capability reverse: R5
      setmode(3'b011, 1'b1);
      hwrite(8'hAB, 1'b1);
      chk_eq("R5 host write ignored in reverse", empty, 1);
      for (int k = 0; k < 5; k++) prx(8'h80 + 8'(k));
      chk_eq("R11 no tx in reverse", txv, 0);
      for (int k = 0; k < 5; k++) begin
         hread();
         chk_eq("R5 reverse data", rdata, 8'h80 + k);
         chk_eq("R5 reverse tag", rcmd, 0);
      end
      chk_eq("R5 drained", empty, 1);

      // diagnostic mode wrap: R10
      setmode(3'b000, 1'b0);
      setmode(3'b110, 1'b0);
      for (int k = 0; k < 17; k++) begin
         hwrite(8'hA0 + 8'(k), 1'b0);
         chk_eq("R10 no tx in diag", txv, 0);
      end
      chk_eq("R10 no overflow in diag", ovf, 0);
      for (int k = 0; k < 18; k++) begin
         hread();
         chk_eq("R10 wrapped read", rdata, 8'hA0 + ((k % 16 == 0) ? 16 : (k % 16)));
      end

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule